// File: doc/BRIEF.md
# Masked Associative Translation Buffer

This block is a fully associative array of address translations. Each entry holds one virtual page-pair number and a page mask. It also holds an 8-bit address-space identifier and a shared global flag. The entry carries two physical halves: one for the even page of the pair and one for the odd page. Each half has a frame number, a 3-bit cache attribute, a dirty flag and a valid flag.

A lookup port and a probe port search every entry in parallel, without any clock. The lookup port returns hit, index and the stored halves. The probe port returns the index, or an all-ones code when nothing matches. Software-style maintenance uses an indexed write port, a read port at a next-to-use pointer that moves only on request, and a flush.

The block does not form the physical address and does not decide on faults. Its client does both.

Top module: `xlate_cam`

## Requirements
- R1: An entry matches a request page number when the two numbers are equal in every bit where the entry's mask is 0. Bits where the mask is 1 are ignored.
- R2: A match also needs one of two things: the entry's global flag is set, or its stored identifier equals the request identifier.
- R3: When several entries match, the lookup and the probe both report the lowest-numbered one.
- R4: The probe result is the matching index with a leading 0 bit. On a miss, the probe result is all ones.
- R5: A half word is packed as follows: frame number from bit 6 up, cache attribute in bits 5:3, dirty in bit 2, valid in bit 1, global in bit 0. On a write, the stored global flag is the AND of bit 0 of both written halves. Reads and lookups return that flag in bit 0 of both halves.
- R6: A write whose index is at or above the entry count changes no entry.
- R7: A flush clears every entry and sets the pointer to 0, taking effect at the next clock edge. A flush overrides a write in the same cycle.
- R8: The read port shows the entry at the pointer. The pointer advances at a clock edge only when rd_adv is high, and it wraps from the last entry to 0.
- R9: An entry whose two valid bits are both clear never matches.
- R10: Synchronous reset leaves the block in the same state as a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| lk_vpn | input | VPN_W | lookup page-pair number |
| lk_asid | input | ASID_W | lookup identifier |
| lk_hit | output | 1 | lookup hit |
| lk_idx | output | IDX_W | lowest matching index |
| lk_mask | output | VPN_W | mask of reported entry |
| lk_lo | output | HALF_W | even half of reported entry, packed |
| lk_hi | output | HALF_W | odd half of reported entry, packed |
| pr_vpn | input | VPN_W | probe page-pair number |
| pr_asid | input | ASID_W | probe identifier |
| pr_idx | output | IDX_W+1 | probe index, all ones on miss |
| wr_en | input | 1 | write strobe |
| wr_idx | input | IDX_W+1 | write index |
| wr_vpn | input | VPN_W | page-pair number to store |
| wr_mask | input | VPN_W | page mask to store |
| wr_asid | input | ASID_W | identifier to store |
| wr_lo | input | HALF_W | even half, packed |
| wr_hi | input | HALF_W | odd half, packed |
| rd_adv | input | 1 | advance pointer after this cycle |
| rd_ptr | output | IDX_W | next-to-use pointer |
| rd_vpn | output | VPN_W | page number at pointer |
| rd_mask | output | VPN_W | mask at pointer |
| rd_asid | output | ASID_W | identifier at pointer |
| rd_lo | output | HALF_W | even half at pointer |
| rd_hi | output | HALF_W | odd half at pointer |
| flush | input | 1 | clear all entries and pointer |

## Verification
Three pairs of operations can share a clock cycle, and the bench provokes each one:

- A write and a lookup of the same page. The bench drives both in one cycle and expects a miss, because the search sees the contents from before the edge. It expects a hit in the following cycle.
- A flush and a write. The bench drives them together and then looks up the written page, which must miss.
- A flush and a pointer advance. The bench drives them together and then reads the pointer, which must be 0.

In every case, a reference model in the bench updates only after it has computed the expected values for the cycle.

// File: rtl/xlate_cam.sv
module xlate_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PIDX_W = IDX_W + 1,
  localparam int HALF_W = PFN_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [VPN_W-1:0]  lk_mask,
  output logic [HALF_W-1:0] lk_lo,
  output logic [HALF_W-1:0] lk_hi,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [PIDX_W-1:0] pr_idx,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [HALF_W-1:0] wr_lo,
  input  logic [HALF_W-1:0] wr_hi,
  input  logic              rd_adv,
  output logic [IDX_W-1:0]  rd_ptr,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [VPN_W-1:0]  rd_mask,
  output logic [ASID_W-1:0] rd_asid,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi,
  input  logic              flush
);
  localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(ENTRIES);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [VPN_W-1:0]  e_mask [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic              e_g    [ENTRIES];
  logic [HALF_W-1:1] e_lo   [ENTRIES];
  logic [HALF_W-1:1] e_hi   [ENTRIES];
  logic [IDX_W-1:0]  ptr;

  logic [ENTRIES-1:0] lk_m, pr_m;
  logic [IDX_W-1:0]   pr_sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic live;
    assign live    = e_lo[i][1] | e_hi[i][1];
    assign lk_m[i] = live && (((lk_vpn ^ e_vpn[i]) & ~e_mask[i]) == '0)
                     && (e_g[i] || lk_asid == e_asid[i]);
    assign pr_m[i] = live && (((pr_vpn ^ e_vpn[i]) & ~e_mask[i]) == '0)
                     && (e_g[i] || pr_asid == e_asid[i]);
  end

  always_comb begin
    lk_idx = '0;
    pr_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_idx = IDX_W'(i);
      if (pr_m[i]) pr_sel = IDX_W'(i);
    end
  end

  assign lk_hit  = |lk_m;
  assign lk_mask = e_mask[lk_idx];
  assign lk_lo   = {e_lo[lk_idx], e_g[lk_idx]};
  assign lk_hi   = {e_hi[lk_idx], e_g[lk_idx]};
  assign pr_idx  = (|pr_m) ? {1'b0, pr_sel} : '1;

  assign rd_ptr  = ptr;
  assign rd_vpn  = e_vpn[ptr];
  assign rd_mask = e_mask[ptr];
  assign rd_asid = e_asid[ptr];
  assign rd_lo   = {e_lo[ptr], e_g[ptr]};
  assign rd_hi   = {e_hi[ptr], e_g[ptr]};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i]  <= '0;
        e_mask[i] <= '0;
        e_asid[i] <= '0;
        e_g[i]    <= 1'b0;
        e_lo[i]   <= '0;
        e_hi[i]   <= '0;
      end
      ptr <= '0;
    end else begin
      if (wr_en && wr_idx < LIMIT) begin
        e_vpn[wr_idx[IDX_W-1:0]]  <= wr_vpn;
        e_mask[wr_idx[IDX_W-1:0]] <= wr_mask;
        e_asid[wr_idx[IDX_W-1:0]] <= wr_asid;
        e_g[wr_idx[IDX_W-1:0]]    <= wr_lo[0] & wr_hi[0];
        e_lo[wr_idx[IDX_W-1:0]]   <= wr_lo[HALF_W-1:1];
        e_hi[wr_idx[IDX_W-1:0]]   <= wr_hi[HALF_W-1:1];
      end
      if (rd_adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_cam_chk.sv
module xlate_cam_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int HALF_W  = 26,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PIDX_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [VPN_W-1:0]  pr_vpn,
  input logic [ASID_W-1:0] pr_asid,
  input logic [PIDX_W-1:0] pr_idx,
  input logic              wr_en,
  input logic [PIDX_W-1:0] wr_idx,
  input logic              rd_adv,
  input logic [IDX_W-1:0]  rd_ptr,
  input logic [VPN_W-1:0]  rd_vpn,
  input logic [VPN_W-1:0]  rd_mask,
  input logic [ASID_W-1:0] rd_asid,
  input logic [HALF_W-1:0] rd_lo,
  input logic [HALF_W-1:0] rd_hi,
  input logic              flush
);
  localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(ENTRIES);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(ENTRIES - 1);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rd_ptr == '0 && !lk_hit && pr_idx == '1));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!flush && rd_adv) |=>
      rd_ptr == (($past(rd_ptr) == LAST) ? '0 : IDX_W'($past(rd_ptr) + 1'b1)));

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!flush && !rd_adv) |=> $stable(rd_ptr));

  assert_probe_agrees_R4: assert property (@(posedge clk) disable iff (rst)
    (pr_vpn == lk_vpn && pr_asid == lk_asid) |->
      (lk_hit ? pr_idx == {1'b0, lk_idx} : pr_idx == '1));

  assert_oob_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= LIMIT && !flush && !rd_adv) |=>
      ($stable(rd_vpn) && $stable(rd_mask) && $stable(rd_asid)
       && $stable(rd_lo) && $stable(rd_hi)));
endmodule

bind xlate_cam xlate_cam_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .HALF_W(HALF_W)
) chk (
  .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit),
  .lk_idx(lk_idx), .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_idx(pr_idx),
  .wr_en(wr_en), .wr_idx(wr_idx), .rd_adv(rd_adv), .rd_ptr(rd_ptr),
  .rd_vpn(rd_vpn), .rd_mask(rd_mask), .rd_asid(rd_asid), .rd_lo(rd_lo),
  .rd_hi(rd_hi), .flush(flush)
);

// File: tb/xlate_cam_test.sv
module xlate_cam_test;
  localparam int PERIOD  = 10;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 19;
  localparam int PFN_W   = 20;
  localparam int ASID_W  = 8;
  localparam int IDX_W   = 3;
  localparam int PIDX_W  = 4;
  localparam int HALF_W  = PFN_W + 6;

  logic clk = 0;
  logic rst = 1;
  always #(PERIOD/2) clk = ~clk;

  logic [VPN_W-1:0]  lk_vpn = '0, pr_vpn = '0, wr_vpn = '0, wr_mask = '0;
  logic [ASID_W-1:0] lk_asid = '0, pr_asid = '0, wr_asid = '0;
  logic              wr_en = 0, rd_adv = 0, flush = 0;
  logic [PIDX_W-1:0] wr_idx = '0;
  logic [HALF_W-1:0] wr_lo = '0, wr_hi = '0;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx, rd_ptr;
  logic [VPN_W-1:0]  lk_mask, rd_vpn, rd_mask;
  logic [HALF_W-1:0] lk_lo, lk_hi, rd_lo, rd_hi;
  logic [PIDX_W-1:0] pr_idx;
  logic [ASID_W-1:0] rd_asid;

  xlate_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) uut (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_mask(lk_mask), .lk_lo(lk_lo), .lk_hi(lk_hi),
    .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_idx(pr_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_adv(rd_adv), .rd_ptr(rd_ptr),
    .rd_vpn(rd_vpn), .rd_mask(rd_mask), .rd_asid(rd_asid), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .flush(flush));

  // reference model of the table
  logic [VPN_W-1:0]  m_vpn [ENTRIES];
  logic [VPN_W-1:0]  m_mask[ENTRIES];
  logic [ASID_W-1:0] m_asid[ENTRIES];
  logic              m_g   [ENTRIES];
  logic [HALF_W-1:0] m_lo  [ENTRIES];
  logic [HALF_W-1:0] m_hi  [ENTRIES];
  int                m_ptr = 0;

  typedef struct {
    string             req;
    bit                hit;
    logic [IDX_W-1:0]  idx;
    logic [VPN_W-1:0]  mask;
    logic [HALF_W-1:0] lo, hi;
    logic [PIDX_W-1:0] pr;
    logic [IDX_W-1:0]  ptr;
    logic [VPN_W-1:0]  rvpn;
    logic [ASID_W-1:0] rasid;
    logic [HALF_W-1:0] rlo, rhi;
  } item_t;

  item_t q[$];
  item_t it;
  int applied = 0, bad = 0;
  bit done = 0;

  function automatic logic [HALF_W-1:0] half(input logic [PFN_W-1:0] pfn, input logic [2:0] c,
                                             input bit d, input bit v, input bit g);
    return {pfn, c, d, v, g};
  endfunction

  function automatic int search(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    for (int i = 0; i < ENTRIES; i++)
      if ((m_lo[i][1] || m_hi[i][1]) && (((v ^ m_vpn[i]) & ~m_mask[i]) == '0)
          && (m_g[i] || m_asid[i] == a))
        return i;
    return -1;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < ENTRIES; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_lo[i] = '0; m_hi[i] = '0;
    end
    m_ptr = 0;
  endtask

  task automatic step(input string req);
    item_t e;
    int l, p;
    l = search(lk_vpn, lk_asid);
    p = search(pr_vpn, pr_asid);
    e.req  = req;
    e.hit  = (l >= 0);
    e.idx  = (l >= 0) ? IDX_W'(l) : '0;
    e.mask = (l >= 0) ? m_mask[l] : '0;
    e.lo   = (l >= 0) ? m_lo[l] : '0;
    e.hi   = (l >= 0) ? m_hi[l] : '0;
    e.pr   = (p >= 0) ? PIDX_W'(p) : '1;
    e.ptr  = IDX_W'(m_ptr);
    e.rvpn = m_vpn[m_ptr];
    e.rasid = m_asid[m_ptr];
    e.rlo  = m_lo[m_ptr];
    e.rhi  = m_hi[m_ptr];
    q.push_back(e);
    if (flush) clear_model();
    else begin
      if (wr_en && wr_idx < ENTRIES) begin
        m_vpn[wr_idx] = wr_vpn; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_lo[0] & wr_hi[0];
        m_lo[wr_idx] = {wr_lo[HALF_W-1:1], wr_lo[0] & wr_hi[0]};
        m_hi[wr_idx] = {wr_hi[HALF_W-1:1], wr_lo[0] & wr_hi[0]};
      end
      if (rd_adv) m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
    end
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    wr_en = 0; rd_adv = 0; flush = 0;
  endtask

  task automatic put(input int idx, input logic [VPN_W-1:0] v, input logic [VPN_W-1:0] m,
                     input logic [ASID_W-1:0] a, input logic [HALF_W-1:0] lo,
                     input logic [HALF_W-1:0] hi);
    wr_en = 1; wr_idx = PIDX_W'(idx); wr_vpn = v; wr_mask = m; wr_asid = a; wr_lo = lo; wr_hi = hi;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    lk_vpn = v; lk_asid = a; pr_vpn = v; pr_asid = a;
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      it = q.pop_front();
      cmp(it.req, "lk_hit", 32'(lk_hit), 32'(it.hit));
      if (it.hit) begin
        cmp(it.req, "lk_idx", 32'(lk_idx), 32'(it.idx));
        cmp(it.req, "lk_mask", 32'(lk_mask), 32'(it.mask));
        cmp(it.req, "lk_lo", 32'(lk_lo), 32'(it.lo));
        cmp(it.req, "lk_hi", 32'(lk_hi), 32'(it.hi));
      end
      cmp(it.req, "pr_idx", 32'(pr_idx), 32'(it.pr));
      cmp(it.req, "rd_ptr", 32'(rd_ptr), 32'(it.ptr));
      cmp(it.req, "rd_vpn", 32'(rd_vpn), 32'(it.rvpn));
      cmp(it.req, "rd_asid", 32'(rd_asid), 32'(it.rasid));
      cmp(it.req, "rd_lo", 32'(rd_lo), 32'(it.rlo));
      cmp(it.req, "rd_hi", 32'(rd_hi), 32'(it.rhi));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    look('0, '0);
    step("R10 reset state, R9 empty entries miss");

    // R5: write idx0; a lookup in the same cycle still sees the old contents
    look(19'h00100, 8'd5);
    put(0, 19'h00100, '0, 8'd5, half(20'h11111, 3'd3, 1, 1, 0), half(20'h22222, 3'd2, 0, 1, 0));
    step("R5 same-cycle write and lookup");
    quiet();
    step("R5 stored fields, R2 asid match");
    look(19'h00100, 8'd6);
    step("R2 asid mismatch misses");

    // R1/R2: masked global entry
    put(1, 19'h00200, 19'h0000F, 8'd3, half(20'h33333, 3'd5, 1, 1, 1), half(20'h44444, 3'd1, 1, 0, 1));
    step("R5 global write");
    quiet();
    look(19'h0020A, 8'd9);
    step("R1 masked bits ignored, R2 global bypass");
    look(19'h00210, 8'd3);
    step("R1 unmasked bit differs");

    // R3: overlapping entry at higher index
    put(2, 19'h00200, 19'h000FF, 8'd0, half(20'h55555, 3'd0, 0, 1, 1), half(20'h66666, 3'd0, 0, 1, 1));
    step("R5 write idx2");
    quiet();
    look(19'h00205, 8'd1);
    step("R3 lowest index wins");
    look(19'h002F0, 8'd1);
    step("R3 only higher entry matches");

    // R6: out-of-range writes
    put(9, 19'h00300, '0, 8'd0, half(20'h77777, 3'd0, 1, 1, 1), half(20'h77777, 3'd0, 1, 1, 1));
    look(19'h00300, 8'd0);
    step("R6 out-of-range write");
    put(15, 19'h00300, '0, 8'd0, half(20'h77777, 3'd0, 1, 1, 1), half(20'h77777, 3'd0, 1, 1, 1));
    step("R6 out-of-range write at top index");
    quiet();
    step("R6 no entry took the write");

    // R9: written entry with both valid bits clear
    put(3, 19'h00400, '0, 8'd0, half(20'h88888, 3'd0, 1, 0, 1), half(20'h99999, 3'd0, 1, 0, 1));
    step("R9 write invalid entry");
    quiet();
    look(19'h00400, 8'd0);
    step("R9 invalid entry never matches");

    // R8: walk the pointer through a full wrap, then hold
    rd_adv = 1;
    for (int i = 0; i < ENTRIES + 2; i++) step("R8 advance and wrap");
    rd_adv = 0;
    step("R8 pointer holds");
    step("R8 pointer holds again");

    // R7: flush with write and advance in the same cycle
    look(19'h00500, 8'd0);
    put(4, 19'h00500, '0, 8'd0, half(20'hAAAAA, 3'd0, 1, 1, 1), half(20'hAAAAA, 3'd0, 1, 1, 1));
    rd_adv = 1;
    flush = 1;
    step("R7 flush with write and advance");
    quiet();
    step("R7 flush won over write");
    look(19'h00100, 8'd5);
    step("R7 earlier entry gone");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [VPN_W-1:0] v;
      wr_en  = ($urandom_range(0, 2) == 0);
      wr_idx = PIDX_W'($urandom_range(0, 11));
      v      = VPN_W'($urandom_range(0, 7) << 4);
      wr_vpn = v | VPN_W'($urandom_range(0, 15));
      wr_mask = ($urandom_range(0, 1) == 1) ? 19'h0000F : '0;
      wr_asid = ASID_W'($urandom_range(0, 3));
      wr_lo = {PFN_W'($urandom), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1))};
      wr_hi = {PFN_W'($urandom), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1))};
      rd_adv = 1'($urandom_range(0, 1));
      flush  = ($urandom_range(0, 60) == 0);
      lk_vpn = VPN_W'($urandom_range(0, 127));
      lk_asid = ASID_W'($urandom_range(0, 3));
      pr_vpn = ($urandom_range(0, 1) == 1) ? lk_vpn : VPN_W'($urandom_range(0, 127));
      pr_asid = ASID_W'($urandom_range(0, 3));
      step("R1 R2 R3 R4 mixed traffic");
    end
    quiet();
    step("R4 final");
    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule